// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Loopback

This block holds the modem control byte and the modem status byte of a 16550-compatible serial port. The host writes the control byte, and the block works out the four modem input lines from it. When a line changes, the block records that change in a delta flag. A host read of the status byte returns the whole byte in the same cycle. The delta flags are then cleared on the next clock edge.

The status lines do not come from pins. When the loopback bit of the control byte is clear, the block drives fixed levels onto them. When the loopback bit is set, four control bits are fed back into the four status lines. Deltas are worked out only on control writes, by comparing the lines before and after the write.

The interrupt logic next to this block uses two outputs. One is the loopback flag. The other is a single flag that is high while any delta is pending.

Top module: `mdm_ctl_top`

## Requirements
- R1: A control write stores bits 4:0 of `wr_data` into `mcr_q` on the next clock edge. Bits 7:5 of `mcr_q` always read 0, whatever was written to them.
- R2: The loopback bit is control bit 4. While it is set, the status bits follow control bits as follows:
  - CTS (`msr_q[4]`) follows RTS (bit 1).
  - DSR (`msr_q[5]`) follows DTR (bit 0).
  - RI (`msr_q[6]`) follows bit 2.
  - DCD (`msr_q[7]`) follows bit 3.
- R3: While loopback is clear, `msr_q[7:4]` reads 4'b1010: DCD and DSR are high, RI and CTS are low.
- R4: A control write that changes a line sets that line's delta bit. CTS sets bit 0, DSR sets bit 1 and DCD sets bit 3.
- R5: The RI delta (`msr_q[2]`) is set only when a write takes RI from 1 to 0. A rising RI leaves that bit unchanged.
- R6: Delta bits accumulate across writes. Only a status read clears them.
- R7: A cycle with `msr_rd` high presents the full status byte on `msr_q`. From the next edge, bits 3:0 are 0 and bits 7:4 are unchanged.
- R8: After reset, `mcr_q` is 0x00, `msr_q` is 0xA0 and all deltas are clear.
- R9: `loopback` equals `mcr_q[4]`, and `any_delta` is the OR of `msr_q[3:0]`.
- R10: A write and a read in the same cycle clear the deltas the read returned. Deltas caused by that write are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mcr_wr | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Write data for the control byte |
| msr_rd | input | 1 | Status byte read strobe; clears the deltas |
| mcr_q | output | 8 | Current control byte |
| msr_q | output | 8 | Current status byte: lines in 7:4, deltas in 3:0 |
| loopback | output | 1 | Loopback mode active |
| any_delta | output | 1 | At least one delta bit set |

## Verification
Some properties are checked by assertions on every cycle:
- each write captures its data into `mcr_q`;
- outside loopback the lines sit at their fixed levels;
- a changed CTS, DSR or DCD line sets its delta;
- a rising RI never sets its delta;
- deltas never drop without a read;
- a plain read always empties them.

The exact loopback wiring of each control bit, and the full byte values, are shown only by the bench. The bench sweeps every ordered pair of 5-bit control values. It also covers accumulation over several writes and a write and read in the same cycle.

// File: rtl/mdm_pkg.sv
// Package: shared constants for the modem control/status block.
// Line vector order is {DCD, RI, DSR, CTS}, which matches the status
// byte layout: state in bits 7:4 and deltas in bits 3:0.
package mdm_pkg;
    localparam int NLINES   = 4;
    localparam int KEEP_W   = 5;
    localparam int LOOP_BIT = 4;
    localparam int LN_CTS   = 0;
    localparam int LN_DSR   = 1;
    localparam int LN_RI    = 2;
    localparam int LN_DCD   = 3;
    // Control bit that feeds each line in loopback, indexed by line.
    localparam int LOOP_SRC [NLINES] = '{1, 0, 2, 3};
    // Line levels used when loopback is off.
    localparam logic [NLINES-1:0] FIXED_LEVEL = 4'b1010;
    // Lines whose delta fires only on a 1-to-0 transition.
    localparam logic [NLINES-1:0] FALL_ONLY   = 4'b0100;
    typedef logic [NLINES-1:0] line_vec_t;
endpackage

// File: rtl/mdm_ctrl_reg.sv
// Module: mdm_ctrl_reg
// Holds the writable low bits of the control byte.
// Assumes: wr_en is a single-cycle strobe from the host decode.
module mdm_ctrl_reg
    import mdm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [KEEP_W-1:0] wr_bits,
    output logic [KEEP_W-1:0] ctrl
);
    // Capture the kept bits on a write; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en)
            ctrl <= wr_bits;
    end

    // R1: every write lands in the register one edge later.
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl == $past(wr_bits));
    // R1: without a write the register holds its value.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));
endmodule

// File: rtl/mdm_status_map.sv
// Module: mdm_status_map
// Maps a control value to the four modem input lines. In loopback,
// each line follows its source control bit; otherwise fixed levels.
// Assumes: purely combinational; used for current and proposed values.
module mdm_status_map
    import mdm_pkg::*;
(
    input  logic [KEEP_W-1:0] ctrl,
    output line_vec_t         lines
);
    // One selector per line: looped-back bit or fixed level.
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign lines[i] = ctrl[LOOP_BIT] ? ctrl[LOOP_SRC[i]] : FIXED_LEVEL[i];
    end
endmodule

// File: rtl/mdm_delta_track.sv
// Module: mdm_delta_track
// Per-line sticky change flags. On an update, the old and new line
// values are compared: a change on most lines, or a falling edge on
// FALL_ONLY lines. A clear wipes the flags, but hits from an update
// in the same cycle are kept.
// Assumes: upd and clr are single-cycle strobes.
module mdm_delta_track
    import mdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      upd,
    input  logic      clr,
    input  line_vec_t cur_lines,
    input  line_vec_t nxt_lines,
    output line_vec_t delta
);
    for (genvar i = 0; i < NLINES; i++) begin : g_dlt
        logic hit;
        // Pick the edge rule for this line.
        if (FALL_ONLY[i]) begin : g_fall
            assign hit = cur_lines[i] & ~nxt_lines[i];
        end else begin : g_any
            assign hit = cur_lines[i] ^ nxt_lines[i];
        end

        // Sticky flag: cleared by a read, set by a qualifying update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                delta[i] <= 1'b0;
            else if (upd || clr)
                delta[i] <= (delta[i] & ~clr) | (hit & upd);
        end

        if (FALL_ONLY[i]) begin : g_chk_fall
            // R5: a rising or steady ring line after a read leaves no flag.
            p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (upd && clr && !(cur_lines[i] && !nxt_lines[i])) |=> !delta[i]);
        end else begin : g_chk_any
            // R4: a changed line always raises its flag.
            p_change_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (upd && (cur_lines[i] != nxt_lines[i])) |=> delta[i]);
        end
    end

    // R6: without a read, no flag that was set ever drops.
    p_accumulate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((delta & $past(delta)) == $past(delta)));
    // R7: a read with no write empties every flag.
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !upd) |=> delta == '0);
endmodule

// File: rtl/mdm_ctl_top.sv
// Module: mdm_ctl_top
// Modem control/status register pair with loopback routing.
// Status byte = {lines[3:0], deltas[3:0]}. A read returns the byte in
// the strobe cycle, and the deltas clear at the following edge.
// Assumes: DATA_W >= 8; strobes are single-cycle, synchronous to clk.
module mdm_ctl_top
    import mdm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mcr_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              msr_rd,
    output logic [DATA_W-1:0] mcr_q,
    output logic [DATA_W-1:0] msr_q,
    output logic              loopback,
    output logic              any_delta
);
    localparam int HI_W = DATA_W - KEEP_W;

    logic [KEEP_W-1:0] ctrl;
    line_vec_t         cur_lines;
    line_vec_t         nxt_lines;
    line_vec_t         delta;
    logic              unused_hi;

    // Upper write bits are discarded by design.
    assign unused_hi = ^wr_data[DATA_W-1:KEEP_W];

    // Control register.
    mdm_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mcr_wr),
        .wr_bits (wr_data[KEEP_W-1:0]),
        .ctrl    (ctrl)
    );

    // Lines from the held control value.
    mdm_status_map u_map_cur (
        .ctrl  (ctrl),
        .lines (cur_lines)
    );

    // Lines the pending write would produce.
    mdm_status_map u_map_nxt (
        .ctrl  (wr_data[KEEP_W-1:0]),
        .lines (nxt_lines)
    );

    // Change flags.
    mdm_delta_track u_dlt (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (mcr_wr),
        .clr       (msr_rd),
        .cur_lines (cur_lines),
        .nxt_lines (nxt_lines),
        .delta     (delta)
    );

    // Output assembly.
    assign mcr_q     = {{HI_W{1'b0}}, ctrl};
    assign msr_q     = {{(DATA_W-2*NLINES){1'b0}}, cur_lines, delta};
    assign loopback  = ctrl[LOOP_BIT];
    assign any_delta = |delta;

    // R3: outside loopback the status lines sit at their fixed levels.
    p_fixed_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_q[LOOP_BIT] |-> msr_q[7:4] == 4'b1010);
    // R1: the top bits of the control byte are never seen set.
    p_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_wr |=> mcr_q[DATA_W-1:KEEP_W] == '0);
endmodule

// File: tb/sim_mdm_ctl_top.sv
module sim_mdm_ctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mcr_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       msr_rd = 1'b0;
    logic [7:0] mcr_q;
    logic [7:0] msr_q;
    logic       loopback;
    logic       any_delta;
    int         n_run = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    mdm_ctl_top #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .mcr_wr(mcr_wr), .wr_data(wr_data),
        .msr_rd(msr_rd), .mcr_q(mcr_q), .msr_q(msr_q),
        .loopback(loopback), .any_delta(any_delta)
    );

    // Expected lines {DCD,RI,DSR,CTS} for a control value.
    function automatic logic [3:0] lines_of(input logic [4:0] m);
        if (m[4]) return {m[3], m[2], m[0], m[1]};
        return 4'b1010;
    endfunction

    // Expected delta hits between two line vectors.
    function automatic logic [3:0] hits_of(input logic [3:0] o, input logic [3:0] n);
        return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] v);
        @(negedge clk); mcr_wr = 1'b1; wr_data = v;
        @(negedge clk); mcr_wr = 1'b0;
    endtask

    task automatic do_rd(output logic [7:0] v);
        @(negedge clk); msr_rd = 1'b1; v = msr_q;
        @(negedge clk); msr_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] got;
        logic [3:0] acc;
        logic [3:0] exp_dl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 mcr", mcr_q, 8'h00);
        chk("R8 msr", msr_q, 8'hA0);
        chk("R8 any_delta", {7'd0, any_delta}, 8'h00);

        // Exhaustive sweep over ordered pairs of control values.
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                logic [7:0] wv;
                logic [3:0] lo, ln;
                wv = {3'((a + b) & 7), 5'(b)};
                do_wr({3'b111, 5'(a)});
                do_rd(got);
                do_wr(wv);
                lo = lines_of(5'(a));
                ln = lines_of(5'(b));
                exp_dl = hits_of(lo, ln);
                chk("R1 mcr", mcr_q, {3'b000, 5'(b)});
                chk("R2 R3 R4 R5 msr", msr_q, {ln, exp_dl});
                chk("R9 any_delta", {7'd0, any_delta}, {7'd0, |exp_dl});
                chk("R9 loopback", {7'd0, loopback}, {7'd0, wv[4]});
                do_rd(got);
                chk("R7 read value", got, {ln, exp_dl});
                chk("R7 after read", msr_q, {ln, 4'h0});
            end
        end

        // R6: accumulation across several writes without a read.
        do_wr(8'h00); do_rd(got);
        acc = 4'h0;
        do_wr(8'h10); acc |= hits_of(lines_of(5'h00), lines_of(5'h10));
        do_wr(8'h16); acc |= hits_of(lines_of(5'h10), lines_of(5'h16));
        do_wr(8'h12); acc |= hits_of(lines_of(5'h16), lines_of(5'h12));
        chk("R6 accumulate", msr_q, {lines_of(5'h12), acc});
        do_wr(8'h12);
        chk("R6 repeat write", msr_q, {lines_of(5'h12), acc});
        repeat (3) @(negedge clk);
        chk("R6 idle hold", msr_q, {lines_of(5'h12), acc});

        // R10: write and read in the same cycle.
        do_wr(8'h10);
        @(negedge clk);
        exp_dl = msr_q[3:0];
        mcr_wr = 1'b1; msr_rd = 1'b1; wr_data = 8'h11;
        got = msr_q;
        @(negedge clk);
        mcr_wr = 1'b0; msr_rd = 1'b0;
        chk("R10 read value", got, {lines_of(5'h10), exp_dl});
        chk("R10 new delta kept", msr_q,
            {lines_of(5'h11), hits_of(lines_of(5'h10), lines_of(5'h11))});

        // R5: RI rising then falling in loopback.
        do_wr(8'h10); do_rd(got);
        do_wr(8'h14);
        chk("R5 rise no flag", msr_q, 8'h40);
        do_wr(8'h10);
        chk("R5 fall flag", msr_q, 8'h04);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule